// File: doc/BRIEF.md
# Store Buffer Drain Timing Tracker

This block keeps the timing bookkeeping for a posted-store buffer placed between a processor pipeline and its memory port. It holds no data. Each entry holds only the number of memory cycles that a buffered store still needs. When a store is posted, the pipeline supplies that cost. The block compares the supplied cycle-counter value with the last moment it accounted for. It uses the elapsed time to retire the oldest entries, or to shorten the remaining cost of the oldest one. From this it tells the pipeline how many cycles the current access must stall.

A store stalls only when the buffer already holds as many entries as the runtime-configured length allows. In that case it waits for the oldest entry to finish. A load must wait until every buffered store has drained. The stall value of each access appears on a registered output one cycle after the strobe. Running totals of stall cycles and of posted store cycles are kept alongside it.

Top module: `store_drain_tracker`

## Requirements
- R1: After reset the stall output, its valid flag and both totals are zero. The buffer is empty and the last accounted cycle is 0, so a load at cycle value 0 reports a stall of 0.
- R2: `stallValid` is high in the cycle after a cycle with `storeStb` or `loadStb` high, and low otherwise. `stallCycles` carries that access's stall while valid and is 0 when not valid.
- R3: A store that finds fewer occupied entries than the effective length reports a stall of 0. Its cost is appended as the newest entry and added to `storeTotal`.
- R4: On every access, the elapsed time is the cycle value minus the last accounted cycle. Oldest entries retire in order while the elapsed time covers their remaining cost, and each retired cost is removed from the elapsed time. Any leftover is subtracted from the oldest surviving entry. The last accounted cycle then becomes the current cycle value.
- R5: A store that, after the drain of R4, finds the occupancy at or above the effective length retires the oldest entry at once. It reports that entry's remaining cost as its stall and moves the last accounted cycle forward by the same amount.
- R6: A load, after the drain of R4, waits for all remaining entries. It reports the sum of their remaining costs, moves the last accounted cycle forward by that sum, and leaves the buffer empty.
- R7: When both strobes are high in one cycle, the store is handled first and then the load. The reported stall is the sum of both parts, and the load waits for the store just posted.
- R8: The effective length is `cfgLen`, raised to 1 when it is 0 and lowered to DEPTH when it exceeds DEPTH.
- R9: When the last accounted cycle lies ahead of the cycle value (the difference has its top bit set), the elapsed time is taken as 0 and no cost is reduced.
- R10: `waitTotal` grows by every reported stall. Neither total changes in a cycle without an access.
- R11: Entries wrap around a ring of DEPTH slots, DEPTH need not be a power of two, and occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycleNow | input | CYC_W | Current value of the free-running cycle counter |
| storeStb | input | 1 | A store is issued this cycle |
| loadStb | input | 1 | A load is issued this cycle |
| storeCost | input | COST_W | Memory cycles the issued store needs |
| cfgLen | input | LEN_W | Runtime buffer length limit |
| stallCycles | output | STALL_W | Stall cycles of the access issued in the previous cycle |
| stallValid | output | 1 | stallCycles belongs to an access |
| waitTotal | output | TOT_W | Running sum of all stall cycles |
| storeTotal | output | TOT_W | Running sum of all posted store costs |

## Verification
The bench builds the tracker with DEPTH 5, 4-bit costs and a 16-bit cycle counter. A ring of five slots exercises index wrap-around on a size that is not a power of two. Length values 0 through 7 then cover both clamping directions of the configured limit, and the 4-bit costs make full and half-drained entries easy to reach within a few accesses. For every length it runs a pseudo-random stream of stores, loads and combined accesses with gaps from 0 to 45 cycles. This reaches the exact-drain boundary, the partial-drain case and the case where the last accounted cycle runs ahead of the counter. Each result is compared with an arithmetic queue model kept in the bench.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  // Strobes from control to the queue datapath.
  typedef struct packed {
    logic drain;  // any access: account for elapsed time
    logic push;   // post a store
    logic flush;  // wait for every pending store
  } sbt_strobe_t;
endpackage

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             storeStb,
  input  logic             loadStb,
  input  logic [LEN_W-1:0] cfgLen,
  output sbt_strobe_t      strb,
  output logic [LEN_W-1:0] effLen
);

  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(DEPTH);

  always_comb begin
    strb.drain = storeStb | loadStb;
    strb.push  = storeStb;
    strb.flush = loadStb;
  end

  always_comb begin
    if (cfgLen == '0)        effLen = LEN_W'(1);
    else if (cfgLen > MaxLen) effLen = MaxLen;
    else                      effLen = cfgLen;
  end

  p_len_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (effLen != '0) && (effLen <= MaxLen));

  p_len_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLen != '0 && cfgLen <= MaxLen) |-> effLen == cfgLen);

endmodule

// File: rtl/sbt_queue.sv
module sbt_queue
  import sbt_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int COST_W  = 8,
  parameter int CYC_W   = 32,
  parameter int LEN_W   = 4,
  parameter int STALL_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sbt_strobe_t        strb,
  input  logic [CYC_W-1:0]   cycleNow,
  input  logic [COST_W-1:0]  storeCost,
  input  logic [LEN_W-1:0]   effLen,
  output logic [STALL_W-1:0] accessStall,
  output logic [COST_W-1:0]  pushCost
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = LEN_W;
  localparam logic [CNT_W-1:0] FullCnt = CNT_W'(DEPTH);

  logic [COST_W-1:0] costQ [DEPTH];
  logic [COST_W-1:0] costN [DEPTH];
  logic [IDX_W-1:0]  headQ, tailQ, headN, tailN, probe;
  logic [CNT_W-1:0]  cntQ, cntN;
  logic [CYC_W-1:0]  lastQ, lastN, elapsedRaw, rem;
  logic              keepGoing;
  logic [STALL_W-1:0] stallSum;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  always_comb begin
    costN     = costQ;
    headN     = headQ;
    tailN     = tailQ;
    cntN      = cntQ;
    lastN     = lastQ;
    stallSum  = '0;
    pushCost  = '0;
    probe     = '0;
    keepGoing = 1'b1;
    elapsedRaw = cycleNow - lastQ;
    rem        = elapsedRaw[CYC_W-1] ? '0 : elapsedRaw;

    // Elapsed-time drain, oldest entry first.
    if (strb.drain) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (keepGoing && cntN != '0 && rem >= CYC_W'(costN[tailN])) begin
          rem   = rem - CYC_W'(costN[tailN]);
          tailN = stepIdx(tailN);
          cntN  = cntN - CNT_W'(1);
        end else begin
          keepGoing = 1'b0;
        end
      end
      if (cntN != '0) costN[tailN] = costN[tailN] - COST_W'(rem);
      lastN = cycleNow;
    end

    // Store: retire the oldest when at the limit, then append.
    if (strb.push) begin
      if (cntN >= effLen) begin
        stallSum = STALL_W'(costN[tailN]);
        tailN    = stepIdx(tailN);
        cntN     = cntN - CNT_W'(1);
      end
      costN[headN] = storeCost;
      headN        = stepIdx(headN);
      cntN         = cntN + CNT_W'(1);
      pushCost     = storeCost;
    end

    // Load: wait for every remaining entry.
    if (strb.flush) begin
      probe = tailN;
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) < cntN) begin
          stallSum = stallSum + STALL_W'(costN[probe]);
          probe    = stepIdx(probe);
        end
      end
      tailN = headN;
      cntN  = '0;
    end

    lastN       = lastN + CYC_W'(stallSum);
    accessStall = stallSum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) costQ[i] <= '0;
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
      lastQ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) costQ[i] <= costN[i];
      headQ <= headN;
      tailQ <= tailN;
      cntQ  <= cntN;
      lastQ <= lastN;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= FullCnt);

  p_ring_consistent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cntQ == '0) || (cntQ == FullCnt)) == (headQ == tailQ));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> cntQ == '0);

  p_push_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && !strb.flush) |=> cntQ != '0);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.drain |=> $stable(cntQ) && $stable(lastQ) && $stable(tailQ) && $stable(headQ));

endmodule

// File: rtl/sbt_acct.sv
module sbt_acct
  import sbt_pkg::*;
#(
  parameter int STALL_W = 12,
  parameter int COST_W  = 8,
  parameter int TOT_W   = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sbt_strobe_t        strb,
  input  logic [STALL_W-1:0] accessStall,
  input  logic [COST_W-1:0]  pushCost,
  output logic [STALL_W-1:0] stallCycles,
  output logic               stallValid,
  output logic [TOT_W-1:0]   waitTotal,
  output logic [TOT_W-1:0]   storeTotal
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stallCycles <= '0;
      stallValid  <= 1'b0;
      waitTotal   <= '0;
      storeTotal  <= '0;
    end else begin
      stallValid  <= strb.drain;
      stallCycles <= strb.drain ? accessStall : '0;
      waitTotal   <= waitTotal + TOT_W'(accessStall);
      storeTotal  <= storeTotal + TOT_W'(pushCost);
    end
  end

  p_valid_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.drain |=> stallValid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.drain |=> !stallValid && stallCycles == '0);

  p_idle_totals_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.drain |=> $stable(waitTotal) && $stable(storeTotal));

endmodule

// File: rtl/store_drain_tracker.sv
module store_drain_tracker
  import sbt_pkg::*;
#(
  parameter int  DEPTH   = 8,
  parameter int  COST_W  = 8,
  parameter int  CYC_W   = 32,
  parameter int  TOT_W   = 48,
  localparam int LEN_W   = $clog2(DEPTH + 1),
  localparam int STALL_W = COST_W + $clog2(DEPTH + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cycleNow,
  input  logic               storeStb,
  input  logic               loadStb,
  input  logic [COST_W-1:0]  storeCost,
  input  logic [LEN_W-1:0]   cfgLen,
  output logic [STALL_W-1:0] stallCycles,
  output logic               stallValid,
  output logic [TOT_W-1:0]   waitTotal,
  output logic [TOT_W-1:0]   storeTotal
);

  sbt_strobe_t        strb;
  logic [LEN_W-1:0]   effLen;
  logic [STALL_W-1:0] accessStall;
  logic [COST_W-1:0]  pushCost;

  sbt_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .storeStb(storeStb), .loadStb(loadStb),
    .cfgLen(cfgLen), .strb(strb), .effLen(effLen)
  );

  sbt_queue #(.DEPTH(DEPTH), .COST_W(COST_W), .CYC_W(CYC_W),
              .LEN_W(LEN_W), .STALL_W(STALL_W)) uQueue (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cycleNow(cycleNow),
    .storeCost(storeCost), .effLen(effLen),
    .accessStall(accessStall), .pushCost(pushCost)
  );

  sbt_acct #(.STALL_W(STALL_W), .COST_W(COST_W), .TOT_W(TOT_W)) uAcct (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accessStall(accessStall),
    .pushCost(pushCost), .stallCycles(stallCycles), .stallValid(stallValid),
    .waitTotal(waitTotal), .storeTotal(storeTotal)
  );

endmodule

// File: tb/tb_store_drain_tracker.sv
`timescale 1ns/1ps
module tb_store_drain_tracker;
  localparam int D  = 5;
  localparam int CW = 4;
  localparam int YW = 16;
  localparam int TW = 24;
  localparam int LW = $clog2(D + 1);
  localparam int SW = CW + $clog2(D + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [YW-1:0] cycleNow = '0;
  logic          storeStb = 1'b0;
  logic          loadStb = 1'b0;
  logic [CW-1:0] storeCost = '0;
  logic [LW-1:0] cfgLen = '0;
  logic [SW-1:0] stallCycles;
  logic          stallValid;
  logic [TW-1:0] waitTotal;
  logic [TW-1:0] storeTotal;

  always #10 clk = ~clk;

  store_drain_tracker #(.DEPTH(D), .COST_W(CW), .CYC_W(YW), .TOT_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cycleNow(cycleNow), .storeStb(storeStb),
    .loadStb(loadStb), .storeCost(storeCost), .cfgLen(cfgLen),
    .stallCycles(stallCycles), .stallValid(stallValid),
    .waitTotal(waitTotal), .storeTotal(storeTotal)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;
  int mq[$];
  int mLast = 0, mWait = 0, mStore = 0, simTime = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic void check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  function automatic logic [15:0] nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // One access: drive at a falling edge, compare one cycle later.
  task automatic access(input bit st, input bit ld, input int cost,
                        input int gap, input int len, input string tag);
    int e, s, eff, sum;
    @(negedge clk);
    simTime   = (simTime + gap) & 'hFFFF;
    cycleNow  = YW'(simTime);
    storeStb  = st;
    loadStb   = ld;
    storeCost = CW'(cost);
    cfgLen    = LW'(len);
    s = 0;
    if (st || ld) begin
      e = (simTime - mLast) & 'hFFFF;
      if (e >= 'h8000) e = 0;                       // R9
      while (mq.size() > 0 && e >= mq[0]) begin      // R4
        e -= mq[0];
        void'(mq.pop_front());
      end
      if (mq.size() > 0) mq[0] -= e;
      mLast = simTime;
    end
    eff = (len < 1) ? 1 : ((len > D) ? D : len);      // R8
    if (st) begin
      if (mq.size() >= eff) begin                    // R5
        s += mq[0];
        mLast += mq[0];
        void'(mq.pop_front());
      end
      mq.push_back(cost);
      mStore += cost;
    end
    if (ld) begin                                    // R6, R7
      sum = 0;
      foreach (mq[i]) sum += mq[i];
      s += sum;
      mLast += sum;
      mq.delete();
    end
    mLast = mLast & 'hFFFF;
    mWait += s;
    @(negedge clk);
    check("R2 valid", int'(stallValid), int'(st || ld));
    check(tag, int'(stallCycles), s);
    check("R10 waitTotal", int'(waitTotal), mWait);
    check("R3 storeTotal", int'(storeTotal), mStore);
    storeStb = 1'b0;
    loadStb  = 1'b0;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check("R2 idle valid", int'(stallValid), 0);
    check("R2 idle stall", int'(stallCycles), 0);
    check("R10 idle waitTotal", int'(waitTotal), mWait);
    check("R10 idle storeTotal", int'(storeTotal), mStore);
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", int'(stallValid), 0);
    check("R1 stall", int'(stallCycles), 0);
    check("R1 waitTotal", int'(waitTotal), 0);
    check("R1 storeTotal", int'(storeTotal), 0);
    access(0, 1, 0, 0, 5, "R1 first load");
    check("R1 literal", int'(stallCycles), 0);

    access(1, 0, 5, 10, 5, "R3 store below limit");
    access(0, 1, 0, 2, 5, "R4 partial drain load");
    check("R4 literal", int'(stallCycles), 3);
    idleCheck();

    // Exact drain boundary then full-buffer store.
    access(1, 0, 7, 100, 2, "R3 fill a");
    access(1, 0, 9, 0, 2, "R3 fill b");
    access(1, 0, 4, 1, 2, "R5 store at limit");
    check("R5 literal", int'(stallCycles), 6);
    access(0, 1, 0, 0, 2, "R9 load behind last cycle");
    check("R9 literal", int'(stallCycles), 13);
    access(1, 0, 3, 200, 2, "R4 exact drain setup");
    access(0, 1, 0, 3, 2, "R4 exact drain");
    check("R4 exact literal", int'(stallCycles), 0);

    // Combined strobes.
    access(1, 0, 6, 10, 3, "R3 pre combined");
    access(1, 1, 8, 2, 3, "R7 combined");
    check("R7 literal", int'(stallCycles), 12);

    // Length clamping.
    access(1, 0, 5, 50, 0, "R8 len0 first");
    access(1, 0, 5, 0, 0, "R8 len0 acts as one");
    check("R8 literal", int'(stallCycles), 5);
    for (int i = 0; i < 6; i++) access(1, 0, 2 + i, 0, 7, "R8 len above depth");
    access(0, 1, 0, 0, 7, "R11 load after wrap");

    // Wrap-around with many full stores.
    for (int i = 0; i < 12; i++) access(1, 0, (i * 7) % 16, i % 3, 5, "R11 ring wrap");
    idleCheck();

    // Near-exhaustive sweep over every length value.
    for (int len = 0; len < (1 << LW); len++) begin
      for (int i = 0; i < 50; i++) begin
        r = nextRand();
        case (r[1:0])
          2'd0, 2'd1: access(1, 0, int'(r[11:8]), int'(r[7:4]) * (r[12] ? 3 : 1), len, "R4 sweep store");
          2'd2:       access(0, 1, 0, int'(r[7:4]) * (r[12] ? 3 : 1), len, "R6 sweep load");
          default:    access(1, 1, int'(r[11:8]), int'(r[7:4]), len, "R7 sweep both");
        endcase
      end
      idleCheck();
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule